// File: doc/BRIEF.md
# Serial Programming Port for a Dual Frequency Synthesizer

This block receives configuration words for two frequency synthesizers over a three-wire serial link made up of a serial clock, a data line and a load strobe. Bits are collected into a 22-bit shift register. When the load strobe rises, the collected word is written into one of four holding registers. The two lowest bits of the word choose the target, and each target has its own field layout.

Two of the targets hold a reference divide value and its mode bits, one for each synthesizer. The other two hold a pulse-swallow (A) count, a main (B) count and two mode bits, again one for each synthesizer. The block drives the contents of all four holding registers as parallel outputs, and a range flag for each of them. A load is refused when its divide value is below 3. In that case the target keeps its previous contents and its flag goes high. Loading continues to work no matter which power-down bits have been stored.

The serial lines are asynchronous to the block clock. They pass through a configurable synchronizer chain, and edges are then detected in the block clock domain.

Top module: `synth_prog_port`

## Requirements
- R1: A bit is taken from `ser_data` on every rising edge of `ser_clk`. Bits enter the most significant end first. The 22 bits received last before a rising edge of `ser_le` form the word.
- R2: A rising edge of `ser_le` writes the word into exactly one holding register, selected by word bits [1:0]. Code 00 selects the synthesizer-2 reference register, 01 the synthesizer-1 reference register, 10 the synthesizer-2 N register and 11 the synthesizer-1 N register. The other three registers are left unchanged.
- R3: In a reference word, bits [16:2] are the reference divide value and bits [21:17] are the five mode bits.
- R4: In an N word, bits [8:2] are the A count, bits [19:9] are the B count and bits [21:20] are the two mode bits, which select prescaler modulus and power-down.
- R5: When the divide value of a word (R for reference words, B for N words) is 0, 1 or 2, the target register keeps its previous contents. Its range flag, which is bit k of `range_err` where k is the select code, is set. The next accepted load to that register clears the flag.
- R6: The divide values at the edges of the legal range are accepted: R = 3 and R = 32767, and B = 3 and B = 2047.
- R7: After reset, all holding-register outputs and all range flags are zero.
- R8: Shifting without a rising edge of `ser_le` leaves every output unchanged. A later rising edge of `ser_le` on its own loads the word that was shifted in.
- R9: When more than 22 bits are shifted before a load, only the last 22 bits are kept.
- R10: After an N word with both mode bits set (power-down) has been loaded, later words still shift and load normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, rising edge writes the word |
| syn1_r_div | output | 15 | Synthesizer 1 reference divide value |
| syn1_r_mode | output | 5 | Synthesizer 1 reference mode bits |
| syn2_r_div | output | 15 | Synthesizer 2 reference divide value |
| syn2_r_mode | output | 5 | Synthesizer 2 reference mode bits |
| syn1_a_cnt | output | 7 | Synthesizer 1 swallow count |
| syn1_b_cnt | output | 11 | Synthesizer 1 main count |
| syn1_n_mode | output | 2 | Synthesizer 1 modulus and power-down bits |
| syn2_a_cnt | output | 7 | Synthesizer 2 swallow count |
| syn2_b_cnt | output | 11 | Synthesizer 2 main count |
| syn2_n_mode | output | 2 | Synthesizer 2 modulus and power-down bits |
| range_err | output | 4 | Per-register refused-load flag, indexed by select code |

## Verification
The bench builds the block with its default widths and a two-stage synchronizer. Because the divide fields are small enough to sweep from the bottom, every value from 0 up to 12 is loaded into each of the four registers, together with the top of each range. This exercises every refused value, the first accepted value and flag clearing, under all four select codes. Overlong bit streams, strobe-only loads and loads after a power-down word are also covered. The expected outputs are sliced from a model word that the bench keeps for each register.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   // select code carried in the two low bits of each word
   typedef enum logic [1:0] {
      SEL_REF2 = 2'b00,
      SEL_REF1 = 2'b01,
      SEL_N2   = 2'b10,
      SEL_N1   = 2'b11
   } latch_sel_e;

   localparam int NUM_SEL = 4;

   // reference-type targets are the codes with bit 1 clear
   function automatic bit sel_is_ref(input int code);
      return (code & 2) == 0;
   endfunction
endpackage

// File: rtl/serial_shifter.sv
module serial_shifter #(
   parameter int WORD_W      = 22,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              load_stb
);
   localparam int LINES = 3;

   if (WORD_W < 2) begin : g_bad_width
      $error("serial_shifter: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("serial_shifter: SYNC_STAGES must not be negative");
   end

   logic [LINES-1:0] raw_lines;
   logic [LINES-1:0] synced;
   assign raw_lines = {ser_le, ser_clk, ser_data};

   if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = raw_lines;
   end else begin : g_sync
      logic [LINES-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '0;
         end else begin
            stg[0] <= raw_lines;
            for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
         end
      end
      assign synced = stg[SYNC_STAGES-1];
   end

   logic s_data, s_clk, s_le;
   assign {s_le, s_clk, s_data} = synced;

   logic clk_q, le_q;
   logic sclk_rise;
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         le_q  <= 1'b0;
      end else begin
         clk_q <= s_clk;
         le_q  <= s_le;
      end
   end

   assign sclk_rise = s_clk & ~clk_q;
   assign load_stb  = s_le & ~le_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shreg <= '0;
      else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], s_data};
   end

   assign word = shreg;

   AST_SHIFT_IN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> shreg[0] == $past(s_data)) else $error("shift entry");  // R1
   AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(shreg)) else $error("shift hold");  // R1
endmodule

// File: rtl/latch_decoder.sv
module latch_decoder #(
   parameter int CTRL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_stb,
   input  logic [CTRL_W-1:0]     ctrl,
   output logic [(1<<CTRL_W)-1:0] load_en
);
   localparam int NUM = 1 << CTRL_W;

   if (CTRL_W < 1) begin : g_bad_ctrl
      $error("latch_decoder: CTRL_W must be at least 1");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_dec
      assign load_en[g] = load_stb && (ctrl == CTRL_W'(g));
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_en)) else $error("more than one target");  // R2
   AST_STB_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> $countones(load_en) == 1) else $error("strobe lost");  // R2
endmodule

// File: rtl/prog_latch.sv
module prog_latch #(
   parameter int PAY_W   = 20,
   parameter int DIV_LSB = 0,
   parameter int DIV_W   = 15,
   parameter int MIN_DIV = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [PAY_W-1:0] pay_in,
   output logic [PAY_W-1:0] stored,
   output logic             range_err
);
   if (DIV_LSB + DIV_W > PAY_W) begin : g_bad_field
      $error("prog_latch: divide field exceeds payload");
   end
   if (MIN_DIV < 0 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
      $error("prog_latch: MIN_DIV out of field range");
   end

   logic [DIV_W-1:0] div_in;
   logic [DIV_W-1:0] div_held;
   logic             div_ok;

   assign div_in   = pay_in[DIV_LSB +: DIV_W];
   assign div_held = stored[DIV_LSB +: DIV_W];
   assign div_ok   = div_in >= DIV_W'(MIN_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored    <= '0;
         range_err <= 1'b0;
      end else if (load_en) begin
         if (div_ok) begin
            stored    <= pay_in;
            range_err <= 1'b0;
         end else begin
            range_err <= 1'b1;
         end
      end
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(stored) && $stable(range_err)) else $error("idle change");  // R8
   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !div_ok |=> $stable(stored) && range_err) else $error("reject");  // R5
   AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (stored != '0) |-> div_held >= DIV_W'(MIN_DIV)) else $error("floor");  // R5
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
   parameter int WORD_W      = 22,
   parameter int CTRL_W      = 2,
   parameter int R_W         = 15,
   parameter int RMODE_W     = 5,
   parameter int A_W         = 7,
   parameter int B_W         = 11,
   parameter int NMODE_W     = 2,
   parameter int MIN_DIV     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_data,
   input  logic                ser_le,
   output logic [R_W-1:0]      syn1_r_div,
   output logic [RMODE_W-1:0]  syn1_r_mode,
   output logic [R_W-1:0]      syn2_r_div,
   output logic [RMODE_W-1:0]  syn2_r_mode,
   output logic [A_W-1:0]      syn1_a_cnt,
   output logic [B_W-1:0]      syn1_b_cnt,
   output logic [NMODE_W-1:0]  syn1_n_mode,
   output logic [A_W-1:0]      syn2_a_cnt,
   output logic [B_W-1:0]      syn2_b_cnt,
   output logic [NMODE_W-1:0]  syn2_n_mode,
   output logic [(1<<CTRL_W)-1:0] range_err
);
   import synth_prog_pkg::*;

   localparam int PAY_W     = WORD_W - CTRL_W;
   localparam int NUM_LATCH = 1 << CTRL_W;
   localparam int R_OFF     = 0;
   localparam int RMODE_OFF = R_W;
   localparam int A_OFF     = 0;
   localparam int B_OFF     = A_W;
   localparam int NMODE_OFF = A_W + B_W;

   if (CTRL_W != 2 || NUM_LATCH != NUM_SEL) begin : g_bad_ctrl
      $error("synth_prog_port: routing needs a two-bit select");
   end
   if (R_W + RMODE_W != PAY_W) begin : g_bad_ref
      $error("synth_prog_port: reference layout does not fill the word");
   end
   if (A_W + B_W + NMODE_W != PAY_W) begin : g_bad_n
      $error("synth_prog_port: N layout does not fill the word");
   end

   logic [WORD_W-1:0]    word;
   logic                 load_stb;
   logic [NUM_LATCH-1:0] load_en;
   logic [PAY_W-1:0]     pay [NUM_LATCH];

   serial_shifter #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .word(word), .load_stb(load_stb)
   );

   latch_decoder #(.CTRL_W(CTRL_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .load_stb(load_stb), .ctrl(word[CTRL_W-1:0]), .load_en(load_en)
   );

   for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
      localparam bit IS_REF  = sel_is_ref(g);
      localparam int DIV_LSB = IS_REF ? R_OFF : B_OFF;
      localparam int DIV_W   = IS_REF ? R_W : B_W;
      prog_latch #(
         .PAY_W(PAY_W), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)
      ) u_latch (
         .clk(clk), .rst_n(rst_n),
         .load_en(load_en[g]),
         .pay_in(word[WORD_W-1:CTRL_W]),
         .stored(pay[g]),
         .range_err(range_err[g])
      );
   end

   localparam int I_R2 = int'(SEL_REF2);
   localparam int I_R1 = int'(SEL_REF1);
   localparam int I_N2 = int'(SEL_N2);
   localparam int I_N1 = int'(SEL_N1);

   assign syn2_r_div  = pay[I_R2][R_OFF +: R_W];
   assign syn2_r_mode = pay[I_R2][RMODE_OFF +: RMODE_W];
   assign syn1_r_div  = pay[I_R1][R_OFF +: R_W];
   assign syn1_r_mode = pay[I_R1][RMODE_OFF +: RMODE_W];
   assign syn2_a_cnt  = pay[I_N2][A_OFF +: A_W];
   assign syn2_b_cnt  = pay[I_N2][B_OFF +: B_W];
   assign syn2_n_mode = pay[I_N2][NMODE_OFF +: NMODE_W];
   assign syn1_a_cnt  = pay[I_N1][A_OFF +: A_W];
   assign syn1_b_cnt  = pay[I_N1][B_OFF +: B_W];
   assign syn1_n_mode = pay[I_N1][NMODE_OFF +: NMODE_W];
endmodule

// File: tb/tb_synth_prog_port.sv
module tb_synth_prog_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [14:0] syn1_r_div, syn2_r_div;
   logic [4:0]  syn1_r_mode, syn2_r_mode;
   logic [6:0]  syn1_a_cnt, syn2_a_cnt;
   logic [10:0] syn1_b_cnt, syn2_b_cnt;
   logic [1:0]  syn1_n_mode, syn2_n_mode;
   logic [3:0]  range_err;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [21:0] exp_w [4];
   logic [3:0]  exp_err;

   always #2.5 clk = ~clk;

   synth_prog_port dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .syn1_r_div(syn1_r_div), .syn1_r_mode(syn1_r_mode),
      .syn2_r_div(syn2_r_div), .syn2_r_mode(syn2_r_mode),
      .syn1_a_cnt(syn1_a_cnt), .syn1_b_cnt(syn1_b_cnt), .syn1_n_mode(syn1_n_mode),
      .syn2_a_cnt(syn2_a_cnt), .syn2_b_cnt(syn2_b_cnt), .syn2_n_mode(syn2_n_mode),
      .range_err(range_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R3 R4: reference fields [16:2]/[21:17]; N fields [8:2]/[19:9]/[21:20]
   task automatic check_all(input string tag);
      chk({tag, " R3 syn2 ref"}, {syn2_r_mode, syn2_r_div}, exp_w[0][21:2]);
      chk({tag, " R3 syn1 ref"}, {syn1_r_mode, syn1_r_div}, exp_w[1][21:2]);
      chk({tag, " R4 syn2 N"}, {syn2_n_mode, syn2_b_cnt, syn2_a_cnt}, exp_w[2][21:2]);
      chk({tag, " R4 syn1 N"}, {syn1_n_mode, syn1_b_cnt, syn1_a_cnt}, exp_w[3][21:2]);
      chk({tag, " R5 flags"}, range_err, exp_err);
   endtask

   task automatic model_load(input logic [21:0] w);
      int a = int'(w[1:0]);
      int dv = (a < 2) ? int'(w[16:2]) : int'(w[19:9]);
      if (dv < 3) exp_err[a] = 1'b1;
      else begin exp_w[a] = w; exp_err[a] = 1'b0; end
   endtask

   task automatic shift_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk) ser_data = v[i];
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
         repeat (3) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_le();
      @(negedge clk) ser_le = 1'b1;
      repeat (3) @(negedge clk);
      ser_le = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic send(input logic [21:0] w);
      shift_bits({10'd0, w}, 22);
      pulse_le();
      model_load(w);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) exp_w[k] = '0;
      exp_err = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R7 reset");

      // R2 R5 R6: sweep reference divide values on both reference targets
      for (int a = 0; a < 2; a++) begin
         for (int v = 0; v < 16; v++) begin
            int r = (v < 13) ? v : (v == 13 ? 32767 : (v == 14 ? 2 : 32766));
            logic [4:0] md = 5'(v * 7 + a);
            send({md, 15'(r), 2'(a)});
            check_all($sformatf("R2 R5 R6 ref a=%0d r=%0d", a, r));
         end
      end
      // R2 R5 R6: sweep B values on both N targets
      for (int a = 2; a < 4; a++) begin
         for (int v = 0; v < 16; v++) begin
            int b = (v < 13) ? v : (v == 13 ? 2047 : (v == 14 ? 1 : 2046));
            logic [6:0] av = 7'(v * 9 + a);
            send({2'(v), 11'(b), av, 2'(a)});
            check_all($sformatf("R2 R5 R6 N a=%0d b=%0d", a, b));
         end
      end

      // R9: extra leading bits are pushed out
      shift_bits({5'b10111, 5'b00000, 22'h0}, 5);
      send({5'h15, 15'd1234, 2'b00});
      check_all("R9 overlong");

      // R8: shift without strobe leaves outputs alone, then strobe alone loads
      shift_bits({10'd0, 2'b01, 11'd777, 7'd33, 2'b11}, 22);
      check_all("R8 no strobe");
      pulse_le();
      model_load({2'b01, 11'd777, 7'd33, 2'b11});
      check_all("R8 strobe only");

      // R10: power-down word, then further loads still work
      send({2'b11, 11'd500, 7'd12, 2'b10});
      check_all("R10 power-down load");
      send({5'h0A, 15'd4321, 2'b01});
      send({2'b00, 11'd99, 7'd1, 2'b10});
      check_all("R10 after power-down");

      // R1: alternating bit pattern confirms bit order
      send({5'b10101, 15'b010101010101010, 2'b00});
      check_all("R1 order");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule